// File: doc/BRIEF.md
# Main Control Decoder for a One-Cycle Processor

This block turns the six-bit primary opcode of a 32-bit instruction into the control points that steer a one-cycle datapath. These control points select the destination register field, choose between a register and an immediate ALU operand, choose between the ALU result and load data for write-back, enable register and memory writes, request a memory read, flag a conditional branch or an absolute jump, and pick sign or zero extension of the 16-bit immediate. Each instruction finishes in one cycle, so the decoder holds no state. Its outputs are a pure function of the opcode.

Decoding happens in two levels. This block never sees the function field. For register-to-register instructions it emits a coarse ALU class, and a separate decoder next to the ALU refines that class. The recognised instruction kinds are register-to-register, OR-immediate, load word, store word, branch-if-equal and jump. Any other opcode produces an all-zero control word, so the instruction leaves registers and memory untouched.

Top module: `main_ctl_decoder`

## Requirements
- R1: Opcode 000000 (register-to-register) gives reg_dst_o=1, alu_src_o=0, mem_to_reg_o=0, reg_wr_o=1 and alu_class_o=2'b10. All other outputs are 0.
- R2: Opcode 001101 (OR-immediate) gives alu_src_o=1, reg_wr_o=1, ext_sign_o=0 (zero extension) and alu_class_o=2'b11. All other outputs are 0.
- R3: Opcode 100011 (load word) gives alu_src_o=1, mem_to_reg_o=1, reg_wr_o=1, mem_rd_o=1, ext_sign_o=1 and alu_class_o=2'b00 (add). reg_dst_o is 0 and all other outputs are 0.
- R4: Opcode 101011 (store word) gives alu_src_o=1, mem_wr_o=1, ext_sign_o=1, reg_wr_o=0 and alu_class_o=2'b00. All other outputs are 0.
- R5: Opcode 000100 (branch-if-equal) gives branch_o=1, alu_src_o=0, reg_wr_o=0 and alu_class_o=2'b01 (subtract). All other outputs are 0.
- R6: Opcode 000010 (jump) gives jump_o=1. Every other output, including alu_class_o, is 0.
- R7: Every opcode outside the six above drives all outputs to 0. In particular, no register write, memory write, memory read, branch or jump is requested.
- R8: At most one of mem_wr_o, mem_rd_o, branch_o and jump_o is 1 for any opcode. reg_wr_o is never 1 together with mem_wr_o, branch_o or jump_o.
- R9: The outputs depend only on the present opcode. They settle within the same cycle that the opcode changes, and earlier opcodes have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode, instruction bits 31..26 |
| reg_dst_o | output | 1 | 1 selects the rd field (bits 15..11) as destination, 0 selects rt (bits 20..16) |
| alu_src_o | output | 1 | 1 selects the extended immediate as second ALU operand |
| mem_to_reg_o | output | 1 | 1 selects load data for register write-back |
| reg_wr_o | output | 1 | Register file write enable |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_rd_o | output | 1 | Data memory read request |
| branch_o | output | 1 | Conditional branch on equality |
| jump_o | output | 1 | Absolute jump |
| ext_sign_o | output | 1 | 1 sign-extends, 0 zero-extends the immediate |
| alu_class_o | output | 2 | 00 add, 01 subtract, 10 defer to function field, 11 OR |

## Verification
The case that stimulus reaches least easily is an unused opcode that sits one bit away from a recognised one. An encoding bug there would either give the instruction a write enable or merge two control rows. To cover it, the bench sweeps all 64 opcode values and compares each control word with an independent model. It also checks the exclusivity rules on every word. A separate check changes the opcode in the middle of a cycle, first from a store to an unused code, then to a load. This shows that the outputs follow the opcode at once and keep nothing from earlier values.

// File: rtl/main_ctl_pkg.sv
package main_ctl_pkg;

  localparam int OP_W      = 6;
  localparam int CLASS_W   = 2;
  localparam int NUM_KINDS = 6;

  typedef enum logic [CLASS_W-1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10,
    ALU_OR   = 2'b11
  } alu_class_e;

  typedef enum int {
    K_REG  = 0,
    K_ORI  = 1,
    K_LOAD = 2,
    K_STOR = 3,
    K_BEQ  = 4,
    K_JMP  = 5
  } kind_e;

  typedef struct packed {
    logic       reg_dst;
    logic       alu_src;
    logic       mem_to_reg;
    logic       reg_wr;
    logic       mem_wr;
    logic       mem_rd;
    logic       branch;
    logic       jump;
    logic       ext_sign;
    alu_class_e alu_class;
  } ctrl_t;

  function automatic logic [OP_W-1:0] kind_opcode(input int k);
    case (k)
      K_REG:   kind_opcode = 6'b000000;
      K_ORI:   kind_opcode = 6'b001101;
      K_LOAD:  kind_opcode = 6'b100011;
      K_STOR:  kind_opcode = 6'b101011;
      K_BEQ:   kind_opcode = 6'b000100;
      default: kind_opcode = 6'b000010;
    endcase
  endfunction

  // don't-care fields are held at 0
  function automatic ctrl_t kind_row(input int k);
    ctrl_t r;
    r = '0;
    case (k)
      K_REG:  begin r.reg_dst = 1'b1; r.reg_wr = 1'b1; r.alu_class = ALU_FUNC; end
      K_ORI:  begin r.alu_src = 1'b1; r.reg_wr = 1'b1; r.alu_class = ALU_OR; end
      K_LOAD: begin
        r.alu_src = 1'b1; r.mem_to_reg = 1'b1; r.reg_wr = 1'b1;
        r.mem_rd = 1'b1; r.ext_sign = 1'b1; r.alu_class = ALU_ADD;
      end
      K_STOR: begin r.alu_src = 1'b1; r.mem_wr = 1'b1; r.ext_sign = 1'b1; r.alu_class = ALU_ADD; end
      K_BEQ:  begin r.branch = 1'b1; r.alu_class = ALU_SUB; end
      default: r.jump = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/op_matcher.sv
module op_matcher
  import main_ctl_pkg::*;
(
  input  logic [OP_W-1:0]      op_i,
  output logic [NUM_KINDS-1:0] hit_o
);

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_match
    assign hit_o[k] = (op_i == kind_opcode(k));
  end

  always_comb begin
    // R7
    hit_onehot_chk: assert ($onehot0(hit_o))
      else $error("opcode matched more than one kind");
  end

endmodule

// File: rtl/ctrl_rows.sv
module ctrl_rows
  import main_ctl_pkg::*;
(
  input  logic [NUM_KINDS-1:0] hit_i,
  output ctrl_t                ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (hit_i[k]) ctrl_o = ctrl_t'(ctrl_o | kind_row(k));
    end

    // R8
    mem_excl_chk: assert ($onehot0({ctrl_o.mem_wr, ctrl_o.mem_rd, ctrl_o.branch, ctrl_o.jump}))
      else $error("side-effect controls overlap");
    // R8
    wr_excl_chk: assert (!(ctrl_o.reg_wr && (ctrl_o.mem_wr || ctrl_o.branch || ctrl_o.jump)))
      else $error("register write with store/branch/jump");
    // R7
    idle_chk: assert ((|hit_i) || (ctrl_o == '0))
      else $error("unknown opcode produced controls");
    // R3
    load_path_chk: assert (ctrl_o.mem_to_reg == ctrl_o.mem_rd)
      else $error("write-back select without memory read");
  end

endmodule

// File: rtl/main_ctl_decoder.sv
module main_ctl_decoder
  import main_ctl_pkg::*;
(
  input  logic [5:0] op_i,
  output logic       reg_dst_o,
  output logic       alu_src_o,
  output logic       mem_to_reg_o,
  output logic       reg_wr_o,
  output logic       mem_wr_o,
  output logic       mem_rd_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic       ext_sign_o,
  output logic [1:0] alu_class_o
);

  logic [NUM_KINDS-1:0] hit;
  ctrl_t                ctrl;

  op_matcher i_match (.op_i(op_i), .hit_o(hit));
  ctrl_rows  i_rows  (.hit_i(hit), .ctrl_o(ctrl));

  assign reg_dst_o    = ctrl.reg_dst;
  assign alu_src_o    = ctrl.alu_src;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign reg_wr_o     = ctrl.reg_wr;
  assign mem_wr_o     = ctrl.mem_wr;
  assign mem_rd_o     = ctrl.mem_rd;
  assign branch_o     = ctrl.branch;
  assign jump_o       = ctrl.jump;
  assign ext_sign_o   = ctrl.ext_sign;
  assign alu_class_o  = ctrl.alu_class;

endmodule

// File: tb/test_main_ctl_decoder.sv
module test_main_ctl_decoder;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] op;
  logic reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, mem_rd, branch, jump, ext_sign;
  logic [1:0] alu_class;

  main_ctl_decoder i_main_ctl_decoder (
    .op_i(op), .reg_dst_o(reg_dst), .alu_src_o(alu_src), .mem_to_reg_o(mem_to_reg),
    .reg_wr_o(reg_wr), .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .branch_o(branch),
    .jump_o(jump), .ext_sign_o(ext_sign), .alu_class_o(alu_class)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  function automatic logic [10:0] actual();
    return {reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, mem_rd, branch, jump, ext_sign, alu_class};
  endfunction

  // order: reg_dst alu_src mem_to_reg reg_wr mem_wr mem_rd branch jump ext_sign class[1:0]
  function automatic logic [10:0] model(input logic [5:0] o);
    case (o)
      6'b000000: return 11'b1_0_0_1_0_0_0_0_0_10;
      6'b001101: return 11'b0_1_0_1_0_0_0_0_0_11;
      6'b100011: return 11'b0_1_1_1_0_1_0_0_1_00;
      6'b101011: return 11'b0_1_0_0_1_0_0_0_1_00;
      6'b000100: return 11'b0_0_0_0_0_0_1_0_0_01;
      6'b000010: return 11'b0_0_0_0_0_0_0_1_0_00;
      default:   return 11'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] o);
    case (o)
      6'b000000: return "R1";
      6'b001101: return "R2";
      6'b100011: return "R3";
      6'b101011: return "R4";
      6'b000100: return "R5";
      6'b000010: return "R6";
      default:   return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] o);
    @(posedge clk);
    #1 op = o;
    exp_q.push_back(model(o));
    tag_q.push_back(tag_of(o));
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      logic [10:0] e;
      logic [10:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = actual();
      check(t, a, e);
      // R8 exclusivity on every word
      check("R8", {2'b00, ($countones({mem_wr, mem_rd, branch, jump}) > 1),
                   (reg_wr && (mem_wr || branch || jump))}, 4'b0);
    end
  end

  initial begin
    op = 6'b000000;
    repeat (2) @(posedge clk);
    #5 check("R1", actual(), 11'b1_0_0_1_0_0_0_0_0_10); // output under reset, opcode 0
    rst_ni = 1'b1;
    drive(6'b100011);
    drive(6'b101011);
    drive(6'b000100);
    drive(6'b000010);
    drive(6'b001101);
    drive(6'b111111);
    // near-miss opcodes: one bit from recognised ones
    drive(6'b100111);
    drive(6'b001100);
    drive(6'b000110);
    drive(6'b101010);
    for (int i = 0; i < 64; i++) drive(6'(i));
    @(posedge clk);
    @(posedge clk);
    // R9: changes inside one cycle, no memory of earlier opcodes
    #3 op = 6'b101011;
    #1 check("R9", actual(), model(6'b101011));
    #2 op = 6'b110000;
    #1 check("R9", actual(), 11'b0);
    #2 op = 6'b100011;
    #1 check("R9", actual(), model(6'b100011));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule